// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a single-channel watchdog timer that sits on a simple single-cycle register bus. A free-running reference strobe (nominally one pulse per microsecond) is divided by a programmable 16-bit ratio to form a slower count tick. A down-counter, loaded from a timeout register, decrements once per count tick while the timer is enabled. Software keeps the system alive by writing a restart bit into the status register, which reloads the counter and restarts the prescaler phase.

If software fails to restart in time and the counter reaches zero, the block drives a system reset pulse of fixed length and sets a sticky expiry flag that survives until software clears it with a write of one. Restart and disable are independent. A common shutdown sequence issues a restart and then clears the enable bit, and the block accepts that order. The counter value can be read back at a spare offset so that the remaining time can be observed.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, reads of the control (0x20), timeout (0x24) and status (0x00) registers return 0, and `wdt_rst_out` is low.
- R2: Register map: status at 0x00, control at 0x20, timeout at 0x24, live counter at 0x28; any other offset reads 0. Control keeps only the ratio field in bits 31:16 and the enable flag in bit 7, and its other bits read 0. `bus_rdata` shows the register addressed in the previous cycle.
- R3: While enabled, the counter decreases by one for every P reference strobes, where P is the control ratio field; a ratio of 0 or 1 gives one decrement per strobe.
- R4: On a 0-to-1 change of the enable flag, and whenever the timer is enabled with the counter at 0, the counter is loaded from the timeout register and the prescaler phase is cleared before counting resumes.
- R5: While disabled, reference strobes are ignored: the counter and prescaler phase hold, and no reset pulse is produced.
- R6: Writing status with bit 9 set reloads the counter from the timeout register and clears the prescaler phase, whether or not the timer is enabled; status bit 9 always reads 0.
- R7: When a decrement takes the counter from 1 to 0 while enabled, `wdt_rst_out` goes high on that same clock edge and stays high for RST_CYCLES (default 16) cycles.
- R8: Status bit 0 is a sticky expiry flag, set at the edge the reset pulse starts. Writing status with bit 0 set clears it; writing bit 0 as 0 leaves it unchanged.
- R9: A timeout value of 0 never expires: no reset pulse is produced however many strobes arrive.
- R10: A restart followed by a write clearing the enable flag leaves the counter equal to the timeout value, frozen, with no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Single-cycle reference strobe feeding the prescaler |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| wdt_rst_out | output | 1 | System reset pulse, high for RST_CYCLES cycles on expiry |

## Verification
The assertions take for granted that a restart and a write of the timeout register never share a cycle, which holds because they use different offsets on a bus that carries one access per cycle. They also assume the reference strobe never arrives in the cycle the counter is being reloaded, since such a strobe is deliberately dropped; the stimulus leaves an idle cycle after every enable write and spaces strobes two clock cycles apart. The sweep runs timeout values 1 to 4 against ratios 0 to 3 so that every strobe-to-decrement phase and the exact expiry edge are compared against arithmetic expectations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_LOAD  = 8'h24;
  localparam logic [7:0] OFF_COUNT = 8'h28;

  localparam int BIT_EN      = 7;
  localparam int BIT_RESTART = 9;
  localparam int BIT_EXPIRED = 0;
  localparam int RATIO_LSB   = 16;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             ref_tick,
  input  logic [PRE_W-1:0] ratio,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;
  logic             wrap;

  // ratio 0 and 1 both wrap on every strobe
  assign wrap = ({1'b0, phase_q} + (PRE_W+1)'(1)) >= {1'b0, ratio};
  assign tick = en && ref_tick && !clr && wrap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
    end else if (en && ref_tick) begin
      phase_q <= wrap ? '0 : phase_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             load_evt,
  output logic             expire
);
  logic en_prev_q;

  assign load_evt = restart || (en && !en_prev_q) || (en && count == '0);
  assign expire   = en && tick && !load_evt && count == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q <= 1'b0;
      count     <= '0;
    end else begin
      en_prev_q <= en;
      if (load_evt) begin
        count <= load_val;
      end else if (en && tick && count != '0) begin
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_pulse_stretch.sv
module wdog_pulse_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_q
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= trig || (left_q > CW'(1));
      if (trig) begin
        left_q <= CW'(LEN);
      end else if (left_q != '0) begin
        left_q <= left_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int PRE_W      = 16,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_out
);
  logic             en_q;
  logic [PRE_W-1:0] ratio_q;
  logic [CNT_W-1:0] load_q;
  logic             expired_q;

  logic wr_stat, wr_ctrl, wr_load;
  logic restart, flag_clr;
  logic tick, load_evt, expire;
  logic [CNT_W-1:0] count;

  assign wr_stat  = bus_we && bus_addr == ADDR_W'(OFF_STAT);
  assign wr_ctrl  = bus_we && bus_addr == ADDR_W'(OFF_CTRL);
  assign wr_load  = bus_we && bus_addr == ADDR_W'(OFF_LOAD);
  assign restart  = wr_stat && bus_wdata[BIT_RESTART];
  assign flag_clr = wr_stat && bus_wdata[BIT_EXPIRED];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      ratio_q   <= '0;
      load_q    <= '0;
      expired_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[BIT_EN];
        ratio_q <= bus_wdata[RATIO_LSB +: PRE_W];
      end
      if (wr_load) begin
        load_q <= bus_wdata[CNT_W-1:0];
      end
      if (expire) begin
        expired_q <= 1'b1;
      end else if (flag_clr) begin
        expired_q <= 1'b0;
      end
    end
  end

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .clr     (load_evt),
    .ref_tick(ref_tick),
    .ratio   (ratio_q),
    .tick    (tick)
  );

  wdog_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (en_q),
    .restart (restart),
    .tick    (tick),
    .load_val(load_q),
    .count   (count),
    .load_evt(load_evt),
    .expire  (expire)
  );

  wdog_pulse_stretch #(.LEN(RST_CYCLES)) u_rst (
    .clk    (clk),
    .rst    (rst),
    .trig   (expire),
    .pulse_q(wdt_rst_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == ADDR_W'(OFF_STAT)) begin
        bus_rdata[BIT_EXPIRED] <= expired_q;
      end else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
        bus_rdata[RATIO_LSB +: PRE_W] <= ratio_q;
        bus_rdata[BIT_EN]             <= en_q;
      end else if (bus_addr == ADDR_W'(OFF_LOAD)) begin
        bus_rdata[CNT_W-1:0] <= load_q;
      end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
        bus_rdata[CNT_W-1:0] <= count;
      end
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_out,
  input logic             flag,
  input logic             en,
  input logic             restart,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load
);
  logic [15:0] hi_run_q;

  always_ff @(posedge clk) begin
    if (rst || !rst_out) hi_run_q <= '0;
    else if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 16'd1;
  end

  // R5
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> count == $past(count));

  // R6
  restart_reload_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> count == $past(load));

  // R7
  expiry_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> count == '0);

  // R7
  pulse_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> $past(hi_run_q) >= 16'(RST_CYCLES - 1));

  // R8
  flag_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> flag);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rst_out(wdt_rst_out),
  .flag   (expired_q),
  .en     (en_q),
  .restart(restart),
  .count  (count),
  .load   (load_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_out;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_out(wdt_rst_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic arm(input int ld, input int p);
    wr(8'h24, 32'(ld));
    wr(8'h20, (32'(p) << 16) | 32'h80);
    @(negedge clk);
  endtask

  task automatic quiesce();
    wr(8'h00, 32'h200);
    wr(8'h20, 32'h0);
    wr(8'h00, 32'h1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h20, d); check("R1 ctrl", d, 0);
    rd(8'h24, d); check("R1 load", d, 0);
    rd(8'h00, d); check("R1 status", d, 0);
    check("R1 rst_out", {31'd0, wdt_rst_out}, 0);

    // R2 masking, unused offset, r9 bit of status reads 0 (R6)
    wr(8'h20, 32'hFFFF_FF7F); rd(8'h20, d); check("R2 ctrl mask", d, 32'hFFFF_0000);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'hA5C3_1234); rd(8'h24, d); check("R2 load", d, 32'hA5C3_1234);
    rd(8'h10, d); check("R2 unused offset", d, 0);
    wr(8'h00, 32'h200); rd(8'h00, d); check("R6 status bit9 reads 0", d, 0);
    rd(8'h28, d); check("R6 restart while disabled", d, 32'hA5C3_1234);

    // R3/R4/R7/R8 sweep
    for (int ld = 1; ld <= 4; ld++) begin
      for (int p = 0; p <= 3; p++) begin
        int pe;
        pe = (p == 0) ? 1 : p;
        arm(ld, p);
        rd(8'h28, d); check("R4 load on enable", d, 32'(ld));
        for (int k = 1; k <= ld * pe; k++) begin
          strobe();
          if (k < ld * pe) begin
            check("R7 no early reset", {31'd0, wdt_rst_out}, 0);
            rd(8'h28, d); check("R3 count", d, 32'(ld - k / pe));
          end else begin
            check("R7 reset at expiry", {31'd0, wdt_rst_out}, 1);
            n = 0;
            while (wdt_rst_out && n < 100) begin n++; @(negedge clk); end
            check("R7 pulse length", 32'(n), RSTC);
            rd(8'h28, d); check("R4 reload at zero", d, 32'(ld));
            rd(8'h00, d); check("R8 flag set", d, 1);
          end
        end
        quiesce();
      end
    end

    // R8 sticky: write 0 keeps, write 1 clears
    arm(1, 1); strobe();
    repeat (RSTC + 2) @(negedge clk);
    wr(8'h00, 32'h0); rd(8'h00, d); check("R8 write0 keeps", d, 1);
    wr(8'h00, 32'h1); rd(8'h00, d); check("R8 write1 clears", d, 0);
    quiesce();

    // R6 restart clears phase, mid-count
    arm(5, 3);
    strobe(); strobe(); strobe(); strobe();
    rd(8'h28, d); check("R3 pre-restart", d, 4);
    wr(8'h00, 32'h200);
    strobe(); strobe();
    rd(8'h28, d); check("R6 reload, phase cleared", d, 5);
    strobe();
    rd(8'h28, d); check("R6 first tick after restart", d, 4);

    // R5 disabled freezes
    wr(8'h20, 32'h0003_0000);
    for (int i = 0; i < 20; i++) strobe();
    rd(8'h28, d); check("R5 frozen count", d, 4);
    check("R5 no reset", {31'd0, wdt_rst_out}, 0);

    // R10 restart then disable
    wr(8'h20, 32'h0003_0080); @(negedge clk);
    strobe(); strobe(); strobe();
    wr(8'h00, 32'h200); wr(8'h20, 32'h0);
    for (int i = 0; i < 30; i++) strobe();
    rd(8'h28, d); check("R10 count equals load", d, 5);
    check("R10 no reset", {31'd0, wdt_rst_out}, 0);

    // R9 zero timeout never expires
    arm(0, 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin strobe(); if (wdt_rst_out) n++; end
    check("R9 zero timeout", 32'(n), 0);
    rd(8'h00, d); check("R9 flag clear", d, 0);
    quiesce();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule